// File: doc/BRIEF.md
# Hint-Guided Cache Replacement Selector

This block picks the line to replace when a set-associative cache misses. It keeps three things for every line of every set: a least-recently-used age rank, a valid bit and two locality hints that arrive with each memory access. The first hint asks that a line be discarded early. The second asks that a line be kept, and it is held as a small counter that runs down as replacements happen. The cache controller presents one access per cycle: the set index, whether it hit and in which way, and the two hint bits. One cycle after a miss, the block returns the way to refill.

Hints only matter when a miss needs a victim. A hit only refreshes the age order. A miss fills the chosen way and updates all of the set's state in the same edge, so a second access to the same set on the next cycle already sees the new order. Victim choice is a short priority chain over the set's ways: first an invalid line, then a discard-marked line, then the oldest unprotected line, and last the oldest line of all. The counters of the other lines in the set run down on each fill, so a protected line cannot hold its place forever.

Top module: `hint_victim_sel`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) invalidates every line in every set, clears all hints and counters, and holds vic_valid low. The first misses to a set after reset take ways 0, 1, 2, 3 in that order.
- R2: An access sampled with req_valid high and req_hit low makes vic_valid high for exactly the following cycle, with vic_way valid alongside it. A hit or an idle cycle leaves vic_valid low.
- R3: If the indexed set holds an invalid line, the victim is the invalid way with the lowest index.
- R4: When all lines are valid and at least one is discard-marked (req_evict was set when it was filled), the victim is the discard-marked line with the greatest age, even if it is not the least recently used.
- R5: When all lines are valid and none is discard-marked, the victim is the line with the greatest age among those whose keep counter is zero.
- R6: When every line in the set has a non-zero keep counter and none is discard-marked, the victim is the plain least-recently-used line (age WAYS-1).
- R7: The filled way becomes most recently used (age 0) and valid. Lines younger than its old age age by one. It takes its hints from the missing access: a discard mark if req_evict=1; otherwise, if req_keep=1, a keep counter of 7 (the 3-bit maximum). If both hints are set, only the discard mark is taken.
- R8: A hit makes the hit way age 0 and ages by one the lines that were younger than it. Hint bits presented with a hit change no stored hint.
- R9: Each miss decrements, saturating at zero, the keep counter of every other line in that set. A line whose counter has reached zero is no longer protected.
- R10: Sets are independent: an access to one set changes no state of any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | An access is presented this cycle |
| req_set | input | $clog2(SETS) | Set index of the access |
| req_hit | input | 1 | The access hit in the cache |
| req_hit_way | input | $clog2(WAYS) | Way that hit, used when req_hit is high |
| req_keep | input | 1 | Keep hint of the access |
| req_evict | input | 1 | Discard hint of the access |
| vic_valid | output | 1 | Victim way is valid this cycle |
| vic_way | output | $clog2(WAYS) | Way chosen for refill |

## Verification
The bench builds sets in which the discard-marked line is young, so a design that falls back to plain age order would pick a different way. It also builds ties between two marked lines whose index order and age order disagree. Protected lines are driven through exactly seven fills, so that counters which fail to decay, decay in the wrong set, or decay one step too early or too late move the victim by one fill. Other cases are an access carrying both hints, a hit carrying a hint that must not stick, a set protected in every way that must fall back to plain age order, and a reset in the middle of the run. Any of these done wrong changes the returned way on a specific step.

// File: rtl/hint_victim_sel.sv
module hint_victim_sel #(
  parameter int WAYS = 4,
  parameter int SETS = 16,
  parameter int KCW  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [$clog2(SETS)-1:0] req_set,
  input  logic                    req_hit,
  input  logic [$clog2(WAYS)-1:0] req_hit_way,
  input  logic                    req_keep,
  input  logic                    req_evict,
  output logic                    vic_valid,
  output logic [$clog2(WAYS)-1:0] vic_way
);
  localparam int WW = $clog2(WAYS);
  localparam int SW = $clog2(SETS);
  localparam logic [KCW-1:0] KMAX = {KCW{1'b1}};
  localparam logic [WW-1:0]  OLDEST = WW'(WAYS - 1);

  logic [WW-1:0]  age_q [SETS][WAYS];
  logic [KCW-1:0] kc_q  [SETS][WAYS];
  logic [WAYS-1:0] val_q [SETS];
  logic [WAYS-1:0] ev_q  [SETS];

  logic [WW-1:0]   cur_age [WAYS];
  logic [WAYS-1:0] cur_val, cur_ev, cur_kp;

  always_comb begin
    cur_val = val_q[req_set];
    cur_ev  = ev_q[req_set];
    for (int w = 0; w < WAYS; w++) begin
      cur_age[w] = age_q[req_set][w];
      cur_kp[w]  = kc_q[req_set][w] != '0;
    end
  end

  logic          inv_hit, ev_hit, nk_hit;
  logic [WW-1:0] inv_w, ev_w, nk_w, lru_w, ev_age, nk_age, victim;

  always_comb begin
    inv_hit = 1'b0; inv_w = '0;
    ev_hit  = 1'b0; ev_w  = '0; ev_age = '0;
    nk_hit  = 1'b0; nk_w  = '0; nk_age = '0;
    lru_w   = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!cur_val[w]) begin
        inv_hit = 1'b1;
        inv_w   = WW'(w);
      end
    for (int w = 0; w < WAYS; w++) begin
      if (cur_val[w] && cur_ev[w] && (!ev_hit || cur_age[w] > ev_age)) begin
        ev_hit = 1'b1; ev_w = WW'(w); ev_age = cur_age[w];
      end
      if (cur_val[w] && !cur_kp[w] && (!nk_hit || cur_age[w] > nk_age)) begin
        nk_hit = 1'b1; nk_w = WW'(w); nk_age = cur_age[w];
      end
      if (cur_age[w] == OLDEST) lru_w = WW'(w);
    end
    victim = inv_hit ? inv_w : ev_hit ? ev_w : nk_hit ? nk_w : lru_w;
  end

  wire           miss    = req_valid && !req_hit;
  wire [WW-1:0]  pivot   = req_hit ? req_hit_way : victim;
  wire [WW-1:0]  piv_age = cur_age[pivot];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        val_q[s] <= '0;
        ev_q[s]  <= '0;
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WW'(w);
          kc_q[s][w]  <= '0;
        end
      end
    end else if (req_valid) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WW'(w) == pivot)
          age_q[req_set][w] <= '0;
        else if (cur_age[w] < piv_age)
          age_q[req_set][w] <= cur_age[w] + 1'b1;
        if (miss) begin
          if (WW'(w) == victim) begin
            val_q[req_set][w] <= 1'b1;
            ev_q[req_set][w]  <= req_evict;
            kc_q[req_set][w]  <= (req_keep && !req_evict) ? KMAX : '0;
          end else if (kc_q[req_set][w] != '0) begin
            kc_q[req_set][w] <= kc_q[req_set][w] - 1'b1;
          end
        end
      end
    end
  end

  logic          vv_q;
  logic [WW-1:0] vw_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      vv_q <= 1'b0;
      vw_q <= '0;
    end else begin
      vv_q <= miss;
      vw_q <= victim;
    end
  end
  assign vic_valid = vv_q;
  assign vic_way   = vw_q;

  logic [SW-1:0]   set_d;
  logic [WAYS-1:0] val_d, evc_d, kp_d;
  always_ff @(posedge clk) begin
    set_d <= req_set;
    val_d <= cur_val;
    evc_d <= cur_val & cur_ev;
    kp_d  <= cur_kp;
  end

  p_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    vic_valid |-> $past(req_valid && !req_hit));

  p_hit_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_hit) |=> !vic_valid);

  p_invalid_first_r3: assert property (@(posedge clk) disable iff (rst)
    (vic_valid && val_d != '1) |-> !val_d[vic_way]);

  p_evict_pref_r4: assert property (@(posedge clk) disable iff (rst)
    (vic_valid && val_d == '1 && evc_d != '0) |-> evc_d[vic_way]);

  p_keep_shield_r5: assert property (@(posedge clk) disable iff (rst)
    (vic_valid && val_d == '1 && evc_d == '0 && kp_d != '1) |-> !kp_d[vic_way]);

  p_fill_mru_r7: assert property (@(posedge clk) disable iff (rst)
    vic_valid |-> (age_q[set_d][vic_way] == '0 && val_q[set_d][vic_way]));
endmodule

// File: tb/hint_victim_sel_test.sv
module hint_victim_sel_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 46;

  logic       clk = 1'b0;
  logic       rst, req_valid, req_hit, req_keep, req_evict;
  logic [3:0] req_set;
  logic [1:0] req_hit_way;
  logic       vic_valid;
  logic [1:0] vic_way;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hint_victim_sel uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_set(req_set),
    .req_hit(req_hit), .req_hit_way(req_hit_way), .req_keep(req_keep),
    .req_evict(req_evict), .vic_valid(vic_valid), .vic_way(vic_way)
  );

  // fields: req tag, set, hit, hit way, keep, evict, expected strobe, expected way
  function automatic logic [15:0] mk(int r, int s, int h, int hw, int k, int e, int xv, int xw);
    return {4'(r), 4'(s), 1'(h), 2'(hw), 1'(k), 1'(e), 1'(xv), 2'(xw)};
  endfunction

  localparam logic [15:0] VEC [NV] = '{
    // set 1: R3 fills, R5 age order, R8 hit refresh
    mk(3,1,0,0,0,0,1,0), mk(3,1,0,0,0,0,1,1), mk(3,1,0,0,0,0,1,2), mk(3,1,0,0,0,0,1,3),
    mk(5,1,0,0,0,0,1,0), mk(2,1,1,1,0,0,0,0), mk(8,1,0,0,0,0,1,2),
    // set 2: R4 young discard line wins, R7 refill clears mark
    mk(3,2,0,0,0,0,1,0), mk(3,2,0,0,0,0,1,1), mk(3,2,0,0,0,1,1,2), mk(3,2,0,0,0,0,1,3),
    mk(4,2,0,0,0,0,1,2), mk(7,2,0,0,0,0,1,0),
    // set 3: R4 tie between marked lines goes to the older
    mk(3,3,0,0,0,1,1,0), mk(3,3,0,0,0,1,1,1), mk(3,3,0,0,0,0,1,2), mk(3,3,0,0,0,0,1,3),
    mk(2,3,1,0,0,0,0,0), mk(4,3,0,0,0,0,1,1), mk(4,3,0,0,0,0,1,0),
    // set 4: R5 shield and R9 decay over seven fills
    mk(3,4,0,0,1,0,1,0), mk(3,4,0,0,0,0,1,1), mk(3,4,0,0,0,0,1,2), mk(3,4,0,0,0,0,1,3),
    mk(5,4,0,0,0,0,1,1), mk(5,4,0,0,0,0,1,2), mk(5,4,0,0,0,0,1,3), mk(9,4,0,0,0,0,1,1),
    mk(9,4,0,0,0,0,1,0),
    // set 5: R6 all protected
    mk(3,5,0,0,1,0,1,0), mk(3,5,0,0,1,0,1,1), mk(3,5,0,0,1,0,1,2), mk(3,5,0,0,1,0,1,3),
    mk(6,5,0,0,0,0,1,0),
    // set 6: R7 both hints, discard wins
    mk(3,6,0,0,1,1,1,0), mk(3,6,0,0,0,0,1,1), mk(3,6,0,0,0,0,1,2), mk(3,6,0,0,0,0,1,3),
    mk(2,6,1,0,0,0,0,0), mk(7,6,0,0,0,0,1,0),
    // set 7: R8 hint on a hit does not stick
    mk(3,7,0,0,0,0,1,0), mk(3,7,0,0,0,0,1,1), mk(3,7,0,0,0,0,1,2), mk(3,7,0,0,0,0,1,3),
    mk(8,7,1,0,0,1,0,0), mk(8,7,0,0,0,0,1,1)
  };

  task automatic check(input int r, input logic [2:0] act, input logic [2:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: strobe/way got %b/%0d expected %b/%0d", r, act[2], act[1:0], exp[2], exp[1:0]);
    end
  endtask

  task automatic step(input logic [15:0] v);
    @(negedge clk);
    req_valid = 1'b1;
    req_set = v[11:8]; req_hit = v[7]; req_hit_way = v[6:5];
    req_keep = v[4]; req_evict = v[3];
    @(negedge clk);
    req_valid = 1'b0;
    check(int'(v[15:12]), {vic_valid, v[2] ? vic_way : 2'b00}, v[2:0]);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_set = '0; req_hit = 1'b0;
    req_hit_way = '0; req_keep = 1'b0; req_evict = 1'b0;
    do_reset();
    check(1, {vic_valid, 2'b00}, 3'b000); // R1 strobe low after reset
    @(negedge clk);
    check(2, {vic_valid, 2'b00}, 3'b000); // R2 idle cycle
    for (int i = 0; i < NV; i++) step(VEC[i]);
    @(negedge clk);
    check(2, {vic_valid, 2'b00}, 3'b000); // R2 strobe lasts one cycle
    step(mk(10,9,0,0,0,0,1,0));   // R10 untouched set still empty
    step(mk(10,1,0,0,0,0,1,3));   // R10 set 1 order kept across others
    do_reset();
    check(1, {vic_valid, 2'b00}, 3'b000); // R1
    step(mk(1,4,0,0,0,0,1,0));    // R1 lines invalid again
    step(mk(1,4,0,0,0,0,1,1));    // R1
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule